// File: doc/BRIEF.md
# Interrupt Cause and Mask Unit

This block collects hardware interrupt events into a 32-bit pending-cause word. It also holds three mask words, all reached through a small synchronous register port. A one-cycle pulse on an event input line latches the matching cause bit. Software acknowledges causes with a write to the cause word: each position written with zero is cleared, and each position written with one keeps its current value. Bit 0 of the cause word is never stored. It always reads as the OR of bits 31:1, so a single bit test tells software whether anything is pending.

Two of the mask words gate the cause word onto two level-sensitive interrupt outputs: one toward the processor and one toward the peripheral bus. The third mask word holds a six-bit system-error enable field for use elsewhere. Each mask stores only its implemented bit positions, and the others read back as zero. Reads are combinational from the selected register. A write takes effect at the next rising clock edge.

Top module: `irq_cause_unit`

## Requirements
- R1: After reset, all four registers read 0x00000000 and both `cpu_irq` and `pci_irq` are low.
- R2: A high level on `evt_in[k]` (k in 1..31) during a clock edge sets cause bit k. `evt_in[0]` has no effect.
- R3: Writing the cause register (`reg_addr` = 0) clears every bit in 31:1 where the write data holds 0 and keeps every bit where it holds 1. A write never sets a cause bit.
- R4: When an event and a clearing write hit the same cause bit on the same edge, the bit ends up set.
- R5: Cause bit 0 reads 1 when any of bits 31:1 is set and 0 otherwise. The value written to bit 0 has no effect.
- R6: The CPU mask register (`reg_addr` = 1) stores the write data ANDed with 0x3C3FFFFE.
- R7: The PCI mask register (`reg_addr` = 2) stores the write data ANDed with 0x03FFFFFE.
- R8: The system-error mask register (`reg_addr` = 3) stores the write data ANDed with 0x0000003F.
- R9: `cpu_irq` is high exactly when (cause AND CPU mask) has a set bit in 31:1.
- R10: `pci_irq` is high exactly when (cause AND PCI mask) has a set bit in 31:1.
- R11: A write changes only the register selected by `reg_addr`, and `reg_rdata` returns the register selected by `reg_addr`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Write strobe for the selected register |
| reg_addr | input | 2 | Register select: 0 cause, 1 CPU mask, 2 PCI mask, 3 system-error mask |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the selected register |
| evt_in | input | 32 | Event set lines; bit 0 is unused |
| cpu_irq | output | 1 | Masked processor interrupt level |
| pci_irq | output | 1 | Masked peripheral-bus interrupt level |

## Verification
A lost or stuck cause bit appears on `reg_rdata` at the first read after the edge that should have changed it. The same fault reaches `cpu_irq` or `pci_irq` in that same cycle when the bit is enabled in a mask. A wrong mask-implementation pattern shows up in a single write-all-ones and read-back. It also shows up as an interrupt raised by a cause bit that sits in an unimplemented mask position. A wrong set-versus-clear priority can only be seen by hitting both on one edge, so the bench does that explicitly.

// File: rtl/irq_pkg.sv
package irq_pkg;

    localparam int WORD_W = 32;
    localparam int SEL_W  = 2;

    // register selector values seen on the register port
    typedef enum logic [SEL_W-1:0] {
        SEL_CAUSE     = 2'd0,
        SEL_CPU_MASK  = 2'd1,
        SEL_PCI_MASK  = 2'd2,
        SEL_SERR_MASK = 2'd3
    } reg_sel_e;

    localparam int NUM_MASKS = 3;

    // implemented-bit patterns, index 0 = CPU, 1 = PCI, 2 = system error
    localparam logic [NUM_MASKS-1:0][WORD_W-1:0] MASK_IMPL = {
        32'h0000_003F,
        32'h03FF_FFFE,
        32'h3C3F_FFFE
    };

endpackage

// File: rtl/irq_cause_reg.sv
module irq_cause_reg #(
    parameter int DATA_W = irq_pkg::WORD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] evt,
    output logic [DATA_W-1:0] cause
);

    typedef struct packed {
        logic [DATA_W-1:1] pend;
    } cause_state_t;

    cause_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // acknowledge: a zero in the write data drops the bit
        if (wr_en) begin
            st_d.pend = st_q.pend & wdata[DATA_W-1:1];
        end
        // new events applied last so they win over a same-cycle clear
        st_d.pend = st_d.pend | evt[DATA_W-1:1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cause = {st_q.pend, |st_q.pend};

endmodule

// File: rtl/irq_mask_reg.sv
module irq_mask_reg #(
    parameter int                DATA_W = irq_pkg::WORD_W,
    parameter logic [DATA_W-1:0] IMPL   = '1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] mask
);

    typedef struct packed {
        logic [DATA_W-1:0] bits;
    } mask_state_t;

    mask_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            st_d.bits = wdata & IMPL;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign mask = st_q.bits;

endmodule

// File: rtl/irq_summary.sv
module irq_summary #(
    parameter int DATA_W = irq_pkg::WORD_W
) (
    input  logic [DATA_W-1:0] cause,
    input  logic [DATA_W-1:0] mask,
    output logic              irq
);

    logic [DATA_W-1:1] hit;

    always_comb begin
        hit = cause[DATA_W-1:1] & mask[DATA_W-1:1];
        irq = |hit;
    end

endmodule

// File: rtl/irq_cause_unit.sv
module irq_cause_unit #(
    parameter int DATA_W = irq_pkg::WORD_W,
    parameter int SEL_W  = irq_pkg::SEL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [SEL_W-1:0]  reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic [DATA_W-1:0] evt_in,
    output logic              cpu_irq,
    output logic              pci_irq
);

    import irq_pkg::*;

    localparam int NIRQ = 2;

    logic [DATA_W-1:0] cause_w;
    logic [DATA_W-1:0] mask_w [NUM_MASKS];
    logic [NIRQ-1:0]   irq_w;
    logic              cause_wr;

    assign cause_wr = reg_wr && (reg_addr == SEL_CAUSE);

    irq_cause_reg #(.DATA_W(DATA_W)) u_cause (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (cause_wr),
        .wdata (reg_wdata),
        .evt   (evt_in),
        .cause (cause_w)
    );

    // mask register g sits at selector g+1
    for (genvar g = 0; g < NUM_MASKS; g++) begin : g_mask
        logic sel_wr;
        assign sel_wr = reg_wr && (reg_addr == SEL_W'(g + 1));
        irq_mask_reg #(
            .DATA_W (DATA_W),
            .IMPL   (MASK_IMPL[g][DATA_W-1:0])
        ) u_mask (
            .clk   (clk),
            .rst_n (rst_n),
            .wr_en (sel_wr),
            .wdata (reg_wdata),
            .mask  (mask_w[g])
        );
    end

    // outputs driven by the CPU and PCI masks (indices 0 and 1)
    for (genvar i = 0; i < NIRQ; i++) begin : g_irq
        irq_summary #(.DATA_W(DATA_W)) u_sum (
            .cause (cause_w),
            .mask  (mask_w[i]),
            .irq   (irq_w[i])
        );
    end

    assign cpu_irq = irq_w[0];
    assign pci_irq = irq_w[1];

    always_comb begin
        unique case (reg_addr)
            SEL_CAUSE:     reg_rdata = cause_w;
            SEL_CPU_MASK:  reg_rdata = mask_w[0];
            SEL_PCI_MASK:  reg_rdata = mask_w[1];
            default:       reg_rdata = mask_w[2];
        endcase
    end

endmodule

// File: rtl/irq_cause_unit_chk.sv
module irq_cause_unit_chk #(
    parameter int DATA_W = irq_pkg::WORD_W,
    parameter int SEL_W  = irq_pkg::SEL_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_wr,
    input logic [SEL_W-1:0]  reg_addr,
    input logic [DATA_W-1:0] reg_wdata,
    input logic [DATA_W-1:0] reg_rdata,
    input logic [DATA_W-1:0] evt_in,
    input logic              cpu_irq,
    input logic              pci_irq,
    input logic [DATA_W-1:0] cause_w,
    input logic [DATA_W-1:0] cpu_mask,
    input logic [DATA_W-1:0] pci_mask,
    input logic [DATA_W-1:0] serr_mask
);

    import irq_pkg::*;

    // R2
    evt_sets_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|evt_in[DATA_W-1:1]) |=>
        ((cause_w[DATA_W-1:1] & $past(evt_in[DATA_W-1:1])) == $past(evt_in[DATA_W-1:1])));

    // R3
    no_spurious_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((cause_w[DATA_W-1:1] & ~$past(cause_w[DATA_W-1:1])
                   & ~$past(evt_in[DATA_W-1:1])) == '0));

    // R3
    ack_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == SEL_CAUSE) |=>
        ((cause_w[DATA_W-1:1] & ~$past(reg_wdata[DATA_W-1:1])
          & ~$past(evt_in[DATA_W-1:1])) == '0));

    // R5
    summary_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == SEL_CAUSE) |-> (reg_rdata[0] == (|reg_rdata[DATA_W-1:1])));

    // R6
    cpu_mask_impl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_mask & ~MASK_IMPL[0][DATA_W-1:0]) == '0);

    // R7
    pci_mask_impl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pci_mask & ~MASK_IMPL[1][DATA_W-1:0]) == '0);

    // R8
    serr_mask_impl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (serr_mask & ~MASK_IMPL[2][DATA_W-1:0]) == '0);

    // R9
    cpu_irq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_irq |-> ((cause_w[DATA_W-1:1] & cpu_mask[DATA_W-1:1]) != '0));

    // R10
    pci_irq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pci_irq |-> ((cause_w[DATA_W-1:1] & pci_mask[DATA_W-1:1]) != '0));

    // R11
    mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_wr && reg_addr == SEL_CPU_MASK) |=> $stable(cpu_mask));

endmodule

bind irq_cause_unit irq_cause_unit_chk #(.DATA_W(DATA_W), .SEL_W(SEL_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .evt_in    (evt_in),
    .cpu_irq   (cpu_irq),
    .pci_irq   (pci_irq),
    .cause_w   (cause_w),
    .cpu_mask  (mask_w[0]),
    .pci_mask  (mask_w[1]),
    .serr_mask (mask_w[2])
);

// File: tb/irq_cause_unit_bench.sv
module irq_cause_unit_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [31:0] evt_in = '0;
    logic        cpu_irq;
    logic        pci_irq;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    irq_cause_unit u_irq_cause_unit (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .evt_in    (evt_in),
        .cpu_irq   (cpu_irq),
        .pci_irq   (pci_irq)
    );

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
        end
    endtask

    // one clock cycle of stimulus: optional write plus event lines
    task automatic cycle(bit wr, logic [1:0] a, logic [31:0] d, logic [31:0] ev);
        @(negedge clk);
        reg_wr = wr; reg_addr = a; reg_wdata = d; evt_in = ev;
        @(negedge clk);
        reg_wr = 1'b0; evt_in = '0;
    endtask

    task automatic wr_reg(logic [1:0] a, logic [31:0] d);
        cycle(1'b1, a, d, 32'h0);
    endtask

    task automatic rd_chk(string tag, logic [1:0] a, logic [31:0] exp);
        reg_addr = a;
        #1;
        check(tag, reg_rdata, exp);
    endtask

    task automatic test_reset();
        rd_chk("R1 cause", 2'd0, 32'h0);
        rd_chk("R1 cpu mask", 2'd1, 32'h0);
        rd_chk("R1 pci mask", 2'd2, 32'h0);
        rd_chk("R1 serr mask", 2'd3, 32'h0);
        check("R1 cpu_irq", {31'h0, cpu_irq}, 32'h0);
        check("R1 pci_irq", {31'h0, pci_irq}, 32'h0);
    endtask

    task automatic test_events();
        cycle(1'b0, 2'd0, 32'h0, 32'h0000_0001);
        rd_chk("R2 bit0 event ignored", 2'd0, 32'h0);
        cycle(1'b0, 2'd0, 32'h0, 32'h8000_0010);
        rd_chk("R2 R5 events set", 2'd0, 32'h8000_0011);
    endtask

    task automatic test_ack();
        wr_reg(2'd0, 32'h7FFF_FFFF);
        rd_chk("R3 clear bit31", 2'd0, 32'h0000_0011);
        wr_reg(2'd0, 32'hFFFF_FFFE);
        rd_chk("R5 bit0 write ignored", 2'd0, 32'h0000_0011);
        wr_reg(2'd0, 32'hFFFF_FFEF);
        rd_chk("R3 R5 clear bit4", 2'd0, 32'h0);
        wr_reg(2'd0, 32'hFFFF_FFFF);
        rd_chk("R3 write cannot set", 2'd0, 32'h0);
    endtask

    task automatic test_race();
        cycle(1'b0, 2'd0, 32'h0, 32'h0000_0020);
        cycle(1'b1, 2'd0, 32'h0, 32'h0000_0020);
        rd_chk("R4 set wins same bit", 2'd0, 32'h0000_0021);
        cycle(1'b1, 2'd0, 32'h0, 32'h0000_0040);
        rd_chk("R4 clear other set new", 2'd0, 32'h0000_0041);
        wr_reg(2'd0, 32'h0);
        rd_chk("R3 clear all", 2'd0, 32'h0);
    endtask

    task automatic test_masks();
        wr_reg(2'd1, 32'hFFFF_FFFF);
        rd_chk("R6 cpu mask impl", 2'd1, 32'h3C3F_FFFE);
        rd_chk("R11 pci untouched", 2'd2, 32'h0);
        rd_chk("R11 serr untouched", 2'd3, 32'h0);
        rd_chk("R11 cause untouched", 2'd0, 32'h0);
        wr_reg(2'd2, 32'hFFFF_FFFF);
        rd_chk("R7 pci mask impl", 2'd2, 32'h03FF_FFFE);
        wr_reg(2'd3, 32'hFFFF_FFFF);
        rd_chk("R8 serr mask impl", 2'd3, 32'h0000_003F);
        rd_chk("R11 cpu kept", 2'd1, 32'h3C3F_FFFE);
        wr_reg(2'd3, 32'hA5A5_A5A5);
        rd_chk("R8 serr pattern", 2'd3, 32'h0000_0025);
    endtask

    task automatic test_irq();
        // bit 30 is unimplemented in both masks
        cycle(1'b0, 2'd0, 32'h0, 32'h4000_0000);
        #1;
        check("R9 unimpl bit no cpu_irq", {31'h0, cpu_irq}, 32'h0);
        check("R10 unimpl bit no pci_irq", {31'h0, pci_irq}, 32'h0);
        wr_reg(2'd0, 32'h0);
        wr_reg(2'd1, 32'h0000_0004);
        wr_reg(2'd2, 32'h0);
        cycle(1'b0, 2'd0, 32'h0, 32'h0000_0008);
        #1;
        check("R9 unmasked bit low", {31'h0, cpu_irq}, 32'h0);
        cycle(1'b0, 2'd0, 32'h0, 32'h0000_0004);
        #1;
        check("R9 masked bit high", {31'h0, cpu_irq}, 32'h1);
        check("R10 pci mask zero", {31'h0, pci_irq}, 32'h0);
        wr_reg(2'd2, 32'h0000_0008);
        #1;
        check("R10 pci bit3 high", {31'h0, pci_irq}, 32'h1);
        wr_reg(2'd0, 32'hFFFF_FFFB);
        #1;
        check("R9 ack drops cpu_irq", {31'h0, cpu_irq}, 32'h0);
        check("R10 pci still high", {31'h0, pci_irq}, 32'h1);
        wr_reg(2'd0, 32'h0);
        #1;
        check("R10 ack drops pci_irq", {31'h0, pci_irq}, 32'h0);
        wr_reg(2'd1, 32'hFFFF_FFFF);
        cycle(1'b0, 2'd0, 32'h0, 32'h2000_0000);
        #1;
        check("R9 bit29 implemented", {31'h0, cpu_irq}, 32'h1);
        check("R10 bit29 unimplemented", {31'h0, pci_irq}, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        test_reset();
        test_events();
        test_ack();
        test_race();
        test_masks();
        test_irq();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%08h expected=%08h", 32'h0, 32'h1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule